// File: doc/BRIEF.md
# Threshold-Driven Shift Unit with Automatic Refill and Flush

This block is the shifting core of a programmable I/O sequencer. It holds an output shift register that takes whole words from a transmit queue and hands them out a few bits at a time. It also holds an input shift register that gathers bits a few at a time and hands whole words to a receive queue. An instruction front end, which is outside this block, sends one request per cycle. The requests are: shift n bits out, shift n bits in, load a word, load a word only when the register is exhausted, and store a word. The block answers in the same cycle with done or stall.

Each register keeps a count of the bits that have passed through it. The counts are compared with programmable thresholds. When the output count reaches its threshold, the output register can be reloaded from the transmit queue in the same cycle as the shift. When the input count reaches its threshold, the input word can be sent to the receive queue and the register cleared, again in the same cycle as the shift. A program can therefore stream data without spending any instruction on reloading or storing. Both queues are reached through plain valid/ready ports. A word moves when valid and ready are both high at a clock edge.

Top module: `io_shift_engine`

## Requirements
- R1: After reset, the output count is 32 (the output register counts as exhausted) and the input register holds 0 with count 0. The first OUT with autopull enabled and `txValid` high takes the queue word and completes without a stall. A PUSH issued straight after reset stores 0.
- R2: OUT n (`opCode`=0; `opBits`=0 means 32) returns n bits on `opOutData`, right-aligned. With `cfgOutRight`=0 it takes the most significant bits first and shifts the register left. With `cfgOutRight`=1 it takes the least significant bits first and shifts the register right.
- R3: IN n (`opCode`=1) takes the low n bits of `opInData`. With `cfgInRight`=0 they enter at bit 0 and the register shifts left. With `cfgInRight`=1 the register shifts right and they enter at the top.
- R4: When an OUT on a non-exhausted register brings the output count to or past the pull threshold, autopull is on and `txValid` is high, the register is reloaded from `txData` in that same cycle (`txReady`=1) and the count becomes 0.
- R5: When an OUT finds the output count at or past the pull threshold, autopull is on and `txValid` is low, the OUT stalls (`opDone`=0, `opStall`=1) and nothing is consumed. Once `txValid` rises, the OUT loads the word and shifts from it in that cycle, and the count becomes n.
- R6: When an IN brings the input count to or past the push threshold and autopush is on, `rxValid` rises in the same cycle with `rxData` holding the word after the shift. If `rxReady` is high, the register and its count are cleared.
- R7: If that autopush meets `rxReady` low, the IN stalls and the input register and count are left unchanged until `rxReady` rises.
- R8: PULL (`opCode`=2) loads the next queue word and clears the output count, and it stalls while `txValid` is low. PULL-IFEMPTY (`opCode`=3) acts like PULL only when the output count has reached the pull threshold. Below the threshold it completes at once, consumes nothing and leaves the output register unchanged.
- R9: PUSH (`opCode`=4) presents the input register on `rxData`, stalls while `rxReady` is low, and clears the register and its count when the word is taken.
- R10: A threshold field of 0 means 32. Both counts saturate at 32.
- R11: With both automatic modes on and both thresholds set to 32, alternating OUT 32 and IN 32 moves one full word from the transmit queue to the receive queue every two cycles, with no stall.
- R12: With autopull off, OUT never stalls and never takes a queue word, even when the register is exhausted. Op codes 5 to 7 complete at once and do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgOutRight | input | 1 | Output register shifts right (LSB first) when 1 |
| cfgInRight | input | 1 | Input register shifts right when 1 |
| cfgAutoPull | input | 1 | Enables automatic reload of the output register |
| cfgAutoPush | input | 1 | Enables automatic flush of the input register |
| cfgPullThresh | input | 5 | Pull threshold in bits, 0 means 32 |
| cfgPushThresh | input | 5 | Push threshold in bits, 0 means 32 |
| opValid | input | 1 | A request is present this cycle |
| opCode | input | 3 | 0 OUT, 1 IN, 2 PULL, 3 PULL-IFEMPTY, 4 PUSH, others no-op |
| opBits | input | 5 | Bit count for OUT and IN, 0 means 32 |
| opInData | input | 32 | Source bits for IN |
| opDone | output | 1 | The request completes this cycle |
| opStall | output | 1 | The request must be held and retried |
| opOutData | output | 32 | Bits shifted out by OUT, right-aligned |
| txValid | input | 1 | The transmit queue holds a word |
| txData | input | 32 | Head word of the transmit queue |
| txReady | output | 1 | The head word is taken at this edge |
| rxValid | output | 1 | A word is offered to the receive queue |
| rxData | output | 32 | Word offered to the receive queue |
| rxReady | input | 1 | The receive queue accepts a word |

## Verification
Every handshake output (`opDone`, `opStall`, `opOutData`, `txReady`, `rxValid`, `rxData`) is a combinational result of the request and the current register state. Each one is due in the same cycle as its request. The bench drives inputs just after a rising edge and compares the outputs at the following falling edge. It moves its own model of both registers and both counts forward only at the next rising edge. As a result, the effect of a shift, reload or flush first shows up in the request made one cycle later, and the checks look for it there.

// File: rtl/io_shift_pkg.sv
package io_shift_pkg;
  localparam logic [2:0] OP_OUT       = 3'd0;
  localparam logic [2:0] OP_IN        = 3'd1;
  localparam logic [2:0] OP_PULL      = 3'd2;
  localparam logic [2:0] OP_PULL_IFEM = 3'd3;
  localparam logic [2:0] OP_PUSH      = 3'd4;

  typedef struct packed {
    logic outShift;    // shift bits out of the output register
    logic osrPreLoad;  // take the queue word as the register source first
    logic osrPostLoad; // reload from the queue after the shift
    logic inShift;     // shift bits into the input register
    logic isrFlush;    // clear the input register and its count
  } strobe_t;
endpackage

// File: rtl/io_shift_dp.sv
module io_shift_dp
  import io_shift_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int FLD_W = $clog2(WORD_W),
  localparam int CNT_W = FLD_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [FLD_W-1:0]  opBits,
  input  logic              outRight,
  input  logic              inRight,
  input  logic [WORD_W-1:0] txData,
  input  logic [WORD_W-1:0] inData,
  output logic [CNT_W-1:0]  osrCount,
  output logic [CNT_W-1:0]  isrCount,
  output logic [CNT_W-1:0]  osrSum,
  output logic [CNT_W-1:0]  isrSum,
  output logic [WORD_W-1:0] outData,
  output logic [WORD_W-1:0] isrWord,
  output logic [WORD_W-1:0] isrMerged
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic [WORD_W-1:0] osrQ, isrQ;
  logic [CNT_W-1:0]  osrCntQ, isrCntQ;
  logic [CNT_W-1:0]  nBits, wMinusN;
  logic [WORD_W-1:0] lowMask, osrSrc, osrRem, inLow;
  logic [CNT_W:0]    osrRaw, isrRaw;

  assign nBits   = (opBits == '0) ? FULL_CNT : {1'b0, opBits};
  assign wMinusN = FULL_CNT - nBits;
  assign lowMask = ~({WORD_W{1'b1}} << nBits);

  // Output side: the source is either the held word or a fresh queue word.
  assign osrSrc = strobe.osrPreLoad ? txData : osrQ;
  always_comb begin
    if (outRight) begin
      outData = osrSrc & lowMask;
      osrRem  = osrSrc >> nBits;
    end else begin
      outData = osrSrc >> wMinusN;
      osrRem  = osrSrc << nBits;
    end
  end

  // Input side merge.
  assign inLow = inData & lowMask;
  always_comb begin
    if (inRight) isrMerged = (isrQ >> nBits) | (inLow << wMinusN);
    else         isrMerged = (isrQ << nBits) | inLow;
  end

  // Saturating counts after a shift of n bits.
  assign osrRaw = {1'b0, osrCntQ} + {1'b0, nBits};
  assign isrRaw = {1'b0, isrCntQ} + {1'b0, nBits};
  assign osrSum = (osrRaw > {1'b0, FULL_CNT}) ? FULL_CNT : osrRaw[CNT_W-1:0];
  assign isrSum = (isrRaw > {1'b0, FULL_CNT}) ? FULL_CNT : isrRaw[CNT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      osrQ    <= '0;
      osrCntQ <= FULL_CNT;
    end else if (strobe.osrPostLoad) begin
      osrQ    <= txData;
      osrCntQ <= '0;
    end else if (strobe.outShift) begin
      osrQ    <= osrRem;
      osrCntQ <= strobe.osrPreLoad ? nBits : osrSum;
    end else if (strobe.osrPreLoad) begin
      osrQ    <= txData;
      osrCntQ <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isrQ    <= '0;
      isrCntQ <= '0;
    end else if (strobe.isrFlush) begin
      isrQ    <= '0;
      isrCntQ <= '0;
    end else if (strobe.inShift) begin
      isrQ    <= isrMerged;
      isrCntQ <= isrSum;
    end
  end

  assign osrCount = osrCntQ;
  assign isrCount = isrCntQ;
  assign isrWord  = isrQ;

  assert_count_cap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (osrCntQ <= FULL_CNT) && (isrCntQ <= FULL_CNT));

  assert_reload_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.osrPostLoad |=> (osrCntQ == '0));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.isrFlush |=> (isrQ == '0) && (isrCntQ == '0));

  assert_osr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.outShift || strobe.osrPreLoad || strobe.osrPostLoad)
      |=> $stable(osrQ) && $stable(osrCntQ));
endmodule

// File: rtl/io_shift_ctrl.sv
module io_shift_ctrl
  import io_shift_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int FLD_W = $clog2(WORD_W),
  localparam int CNT_W = FLD_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic             autoPull,
  input  logic             autoPush,
  input  logic [FLD_W-1:0] pullField,
  input  logic [FLD_W-1:0] pushField,
  input  logic [CNT_W-1:0] osrCount,
  input  logic [CNT_W-1:0] osrSum,
  input  logic [CNT_W-1:0] isrSum,
  input  logic             txValid,
  input  logic             rxReady,
  output strobe_t          strobe,
  output logic             opDone,
  output logic             txReady,
  output logic             rxValid,
  output logic             rxSelMerged
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic [CNT_W-1:0] pullTh, pushTh;
  logic osrExhausted, pushDue, postDue;

  assign pullTh = (pullField == '0) ? FULL_CNT : {1'b0, pullField};
  assign pushTh = (pushField == '0) ? FULL_CNT : {1'b0, pushField};
  assign osrExhausted = osrCount >= pullTh;
  assign pushDue = autoPush && (isrSum >= pushTh);
  assign postDue = autoPull && (osrSum >= pullTh) && txValid;

  always_comb begin
    strobe      = '0;
    opDone      = 1'b0;
    txReady     = 1'b0;
    rxValid     = 1'b0;
    rxSelMerged = 1'b0;
    if (opValid) begin
      case (opCode)
        OP_OUT: begin
          if (autoPull && osrExhausted) begin
            if (txValid) begin
              strobe.osrPreLoad = 1'b1;
              strobe.outShift   = 1'b1;
              txReady           = 1'b1;
              opDone            = 1'b1;
            end
          end else begin
            strobe.outShift = 1'b1;
            opDone          = 1'b1;
            if (postDue) begin
              strobe.osrPostLoad = 1'b1;
              txReady            = 1'b1;
            end
          end
        end
        OP_IN: begin
          if (pushDue) begin
            rxValid     = 1'b1;
            rxSelMerged = 1'b1;
            if (rxReady) begin
              strobe.inShift  = 1'b1;
              strobe.isrFlush = 1'b1;
              opDone          = 1'b1;
            end
          end else begin
            strobe.inShift = 1'b1;
            opDone         = 1'b1;
          end
        end
        OP_PULL, OP_PULL_IFEM: begin
          if (opCode == OP_PULL_IFEM && !osrExhausted) begin
            opDone = 1'b1;
          end else if (txValid) begin
            strobe.osrPreLoad = 1'b1;
            txReady           = 1'b1;
            opDone            = 1'b1;
          end
        end
        OP_PUSH: begin
          rxValid = 1'b1;
          if (rxReady) begin
            strobe.isrFlush = 1'b1;
            opDone          = 1'b1;
          end
        end
        default: opDone = 1'b1;
      endcase
    end
  end

  assert_pop_needs_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txValid);

  assert_single_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.osrPreLoad && strobe.osrPostLoad));

  assert_manual_no_pop_R12: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_OUT && !autoPull) |-> (opDone && !txReady));
endmodule

// File: rtl/io_shift_engine.sv
module io_shift_engine
  import io_shift_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int FLD_W = $clog2(WORD_W),
  localparam int CNT_W = FLD_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgOutRight,
  input  logic              cfgInRight,
  input  logic              cfgAutoPull,
  input  logic              cfgAutoPush,
  input  logic [FLD_W-1:0]  cfgPullThresh,
  input  logic [FLD_W-1:0]  cfgPushThresh,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [FLD_W-1:0]  opBits,
  input  logic [WORD_W-1:0] opInData,
  output logic              opDone,
  output logic              opStall,
  output logic [WORD_W-1:0] opOutData,
  input  logic              txValid,
  input  logic [WORD_W-1:0] txData,
  output logic              txReady,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxData,
  input  logic              rxReady
);
  strobe_t          strobe;
  logic [CNT_W-1:0] osrCount, isrCount, osrSum, isrSum;
  logic [WORD_W-1:0] isrWord, isrMerged;
  logic             rxSelMerged;

  io_shift_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .autoPull(cfgAutoPull), .autoPush(cfgAutoPush),
    .pullField(cfgPullThresh), .pushField(cfgPushThresh),
    .osrCount(osrCount), .osrSum(osrSum), .isrSum(isrSum),
    .txValid(txValid), .rxReady(rxReady), .strobe(strobe),
    .opDone(opDone), .txReady(txReady), .rxValid(rxValid),
    .rxSelMerged(rxSelMerged)
  );

  io_shift_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opBits(opBits),
    .outRight(cfgOutRight), .inRight(cfgInRight), .txData(txData),
    .inData(opInData), .osrCount(osrCount), .isrCount(isrCount),
    .osrSum(osrSum), .isrSum(isrSum), .outData(opOutData),
    .isrWord(isrWord), .isrMerged(isrMerged)
  );

  assign opStall = opValid && !opDone;
  assign rxData  = rxSelMerged ? isrMerged : isrWord;

  assert_stall_no_pop_R5: assert property (@(posedge clk) disable iff (!rstN)
    opStall |-> !txReady);

  assert_push_blocked_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> $stable(isrCount));
endmodule

// File: tb/io_shift_engine_tb.sv
module io_shift_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgOutRight = 0, cfgInRight = 0, cfgAutoPull = 0, cfgAutoPush = 0;
  logic [4:0] cfgPullThresh = 0, cfgPushThresh = 0;
  logic opValid = 0;
  logic [2:0] opCode = 0;
  logic [4:0] opBits = 0;
  logic [31:0] opInData = 0;
  logic opDone, opStall, txReady, rxValid, rxReady = 0, txValid = 0;
  logic [31:0] opOutData, txData = 0, rxData;

  io_shift_engine u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  // Bench model of the two registers and their counts.
  logic [31:0] mOsr, mIsr;
  int mOsrCnt, mIsrCnt;
  logic eDone, eTxR, eRxV;
  logic [31:0] eOut, eRxD;

  function automatic logic [31:0] fOut(logic [31:0] s, int n, bit right);
    logic [63:0] w;
    if (right) w = 64'(s) & ((64'd1 << n) - 64'd1);
    else       w = (64'(s) << n) >> 32;
    return w[31:0];
  endfunction

  function automatic logic [31:0] fRem(logic [31:0] s, int n, bit right);
    logic [63:0] w;
    if (right) w = 64'(s) >> n;
    else       w = 64'(s) << n;
    return w[31:0];
  endfunction

  function automatic logic [31:0] fIn(logic [31:0] r, logic [31:0] d, int n, bit right);
    logic [63:0] low, w;
    low = 64'(d) & ((64'd1 << n) - 64'd1);
    if (right) w = (64'(r) >> n) | (low << (32 - n));
    else       w = (64'(r) << n) | low;
    return w[31:0];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic modelReset();
    mOsr = 0; mOsrCnt = 32; mIsr = 0; mIsrCnt = 0;
  endtask

  task automatic doReset();
    opValid = 0; txValid = 0; rxReady = 0;
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    modelReset();
  endtask

  task automatic step(string tag);
    int n, pth, qth, sum;
    logic [31:0] nOsr, nIsr, merged;
    int nOc, nIc;
    n = (opBits == 0) ? 32 : int'(opBits);
    pth = (cfgPullThresh == 0) ? 32 : int'(cfgPullThresh);
    qth = (cfgPushThresh == 0) ? 32 : int'(cfgPushThresh);
    eDone = 0; eTxR = 0; eRxV = 0; eRxD = 0; eOut = 0;
    nOsr = mOsr; nOc = mOsrCnt; nIsr = mIsr; nIc = mIsrCnt;
    if (opValid) begin
      case (opCode)
        3'd0: if (cfgAutoPull && mOsrCnt >= pth) begin
                if (txValid) begin
                  eTxR = 1; eDone = 1;
                  eOut = fOut(txData, n, cfgOutRight);
                  nOsr = fRem(txData, n, cfgOutRight); nOc = n;
                end
              end else begin
                eDone = 1;
                eOut = fOut(mOsr, n, cfgOutRight);
                nOsr = fRem(mOsr, n, cfgOutRight);
                sum = (mOsrCnt + n > 32) ? 32 : mOsrCnt + n; nOc = sum;
                if (cfgAutoPull && sum >= pth && txValid) begin
                  eTxR = 1; nOsr = txData; nOc = 0;
                end
              end
        3'd1: begin
                merged = fIn(mIsr, opInData, n, cfgInRight);
                sum = (mIsrCnt + n > 32) ? 32 : mIsrCnt + n;
                if (cfgAutoPush && sum >= qth) begin
                  eRxV = 1; eRxD = merged;
                  if (rxReady) begin eDone = 1; nIsr = 0; nIc = 0; end
                end else begin
                  eDone = 1; nIsr = merged; nIc = sum;
                end
              end
        3'd2, 3'd3: if (opCode == 3'd3 && mOsrCnt < pth) eDone = 1;
              else if (txValid) begin eDone = 1; eTxR = 1; nOsr = txData; nOc = 0; end
        3'd4: begin
                eRxV = 1; eRxD = mIsr;
                if (rxReady) begin eDone = 1; nIsr = 0; nIc = 0; end
              end
        default: eDone = 1;
      endcase
    end
    @(negedge clk);
    chk(tag, "opDone", 32'(opDone), 32'(eDone));
    chk(tag, "opStall", 32'(opStall), 32'(opValid && !eDone));
    chk(tag, "txReady", 32'(txReady), 32'(eTxR));
    chk(tag, "rxValid", 32'(rxValid), 32'(eRxV));
    if (eDone && opValid && opCode == 3'd0) chk(tag, "opOutData", opOutData, eOut);
    if (eRxV) chk(tag, "rxData", rxData, eRxD);
    @(posedge clk);
    mOsr = nOsr; mOsrCnt = nOc; mIsr = nIsr; mIsrCnt = nIc;
    #1;
  endtask

  task automatic req(logic [2:0] code, logic [4:0] bits, logic [31:0] din);
    opValid = 1; opCode = code; opBits = bits; opInData = din;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        summary();
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    doReset();

    // R1: reset state, first push stores 0, first autopull OUT takes the word
    cfgAutoPull = 1; cfgPullThresh = 0;
    req(3'd4, 0, 0); rxReady = 1; step("R1");
    req(3'd0, 5'd8, 0); txValid = 1; txData = 32'hA5C3_1234; step("R1");
    chk("R1", "first OUT bits", eOut, 32'h0000_00A5);
    txValid = 0;

    // R2: direction of output shifting
    req(3'd0, 5'd8, 0); step("R2");
    chk("R2", "MSB-first byte", eOut, 32'h0000_00C3);
    cfgOutRight = 1; req(3'd0, 5'd4, 0); step("R2");

    // R4 and R10: reload in the same cycle at a 16-bit threshold
    doReset(); cfgOutRight = 0; cfgAutoPull = 1; cfgPullThresh = 5'd16;
    txValid = 1; txData = 32'h1111_2222;
    req(3'd0, 5'd16, 0); step("R4");
    txData = 32'h3333_4444; req(3'd0, 5'd16, 0); step("R4");
    chk("R4", "reload strobe", 32'(txReady), 32'd1);
    txData = 32'h5555_6666; req(3'd0, 5'd0, 0); step("R10");

    // R5: stall while exhausted and queue empty, then resume
    doReset(); cfgAutoPull = 1; cfgPullThresh = 5'd8; txValid = 1; txData = 32'hDEAD_BEEF;
    req(3'd0, 5'd8, 0); step("R5");
    txValid = 0; req(3'd0, 5'd8, 0); step("R5");
    req(3'd0, 5'd8, 0); step("R5");
    chk("R5", "stall held", 32'(opStall), 32'd1);
    req(3'd0, 5'd8, 0); step("R5");
    txValid = 1; txData = 32'hCAFE_F00D; req(3'd0, 5'd4, 0); step("R5");

    // R3: input shifting both ways
    doReset(); req(3'd1, 5'd4, 32'hFFFF_FFF9); step("R3");
    cfgInRight = 1; req(3'd1, 5'd8, 32'h0000_00AB); step("R3");
    rxReady = 1; req(3'd4, 0, 0); step("R3");

    // R6 and R7: autopush at 16 bits, blocked then accepted
    doReset(); cfgInRight = 0; cfgAutoPush = 1; cfgPushThresh = 5'd16;
    req(3'd1, 5'd8, 32'h12); step("R6");
    rxReady = 0; req(3'd1, 5'd8, 32'h34); step("R7");
    req(3'd1, 5'd8, 32'h34); step("R7");
    chk("R7", "held word", rxData, 32'h0000_1234);
    rxReady = 1; req(3'd1, 5'd8, 32'h34); step("R6");
    req(3'd4, 0, 0); step("R6");

    // R8: PULL blocks; PULL-IFEMPTY idle below threshold
    doReset(); cfgAutoPull = 0; cfgPullThresh = 5'd16;
    req(3'd2, 0, 0); step("R8");
    txValid = 1; txData = 32'h8765_4321; step("R8");
    req(3'd3, 0, 0); step("R8");
    chk("R8", "no pop below threshold", 32'(txReady), 32'd0);
    cfgOutRight = 0; req(3'd0, 5'd16, 0); step("R8");
    chk("R8", "word kept", eOut, 32'h0000_8765);
    req(3'd3, 0, 0); step("R8");

    // R9: explicit store, blocked then accepted
    doReset(); req(3'd1, 5'd12, 32'hABC); rxReady = 0; step("R9");
    req(3'd4, 0, 0); step("R9");
    rxReady = 1; step("R9");
    req(3'd4, 0, 0); step("R9");

    // R12: manual mode never pops; spare codes are no-ops
    doReset(); cfgAutoPull = 0; txValid = 1; txData = 32'h0F0F_0F0F;
    req(3'd0, 5'd0, 0); step("R12");
    req(3'd0, 5'd0, 0); step("R12");
    req(3'd6, 0, 0); step("R12");

    // R11: loopback at one word every two cycles
    doReset(); cfgAutoPull = 1; cfgAutoPush = 1; cfgPullThresh = 0; cfgPushThresh = 0;
    cfgOutRight = 0; cfgInRight = 0; txValid = 1; rxReady = 1;
    for (int k = 0; k < 32; k++) begin
      logic [31:0] word;
      word = 32'h1000_0000 + 32'(k) * 32'h0101_0103;
      txData = word;
      req(3'd0, 5'd0, 0); step("R11");
      req(3'd1, 5'd0, eOut); step("R11");
      chk("R11", "looped word", rxData, word);
      chk("R11", "no stall", 32'(eDone), 32'd1);
    end

    // Random mix against the model
    doReset();
    for (int c = 0; c < 4000; c++) begin
      if (c % 100 == 0) begin
        cfgOutRight = 1'($urandom); cfgInRight = 1'($urandom);
        cfgAutoPull = 1'($urandom); cfgAutoPush = 1'($urandom);
        cfgPullThresh = 5'($urandom); cfgPushThresh = 5'($urandom);
      end
      opValid = ($urandom % 8) != 0;
      opCode = 3'($urandom % 6);
      opBits = 5'($urandom);
      opInData = $urandom;
      txValid = ($urandom % 10) < 7; txData = $urandom;
      rxReady = ($urandom % 10) < 7;
      step("RND");
    end

    summary();
  end
endmodule